// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock Stretching

This block is an I2C target peripheral that runs entirely in a system clock domain. It samples the SCL and SDA lines through synchronizers and detects start and stop conditions. It matches a 7-bit address and moves bytes, most significant bit first, through a single data buffer that a host CPU reads and writes. Both bus lines are driven open-drain. The outputs `scl_pull` and `sda_pull` request that a line be pulled low, and release it otherwise.

When the master writes, each received byte is loaded into the buffer and acknowledged. If the previous byte has not been collected, or an earlier overflow is still pending, the block refuses the byte with a NACK. When the master reads, the block holds SCL low after the address and after every byte the master acknowledges. It keeps SCL low until the host has loaded the buffer and set the clock-release bit. A master NACK ends the read. An event flag marks every completed byte and stays set until software clears it.

Top module: `i2c_byte_slave`

## Requirements
- R1: After reset, both line pulls are inactive. Buffer-full, overflow, write-collision, direction, data/address and event flags are 0, and the clock-release bit is 1.
- R2: An address byte carries the 7-bit address in bits 7:1 and the direction in bit 0 (1 = read). It is acknowledged only when bits 7:1 equal `own_addr[7:1]`, and `own_addr[0]` takes no part in the match. A byte that does not match is NACKed and leaves the flags unchanged.
- R3: On a write, the block acknowledges each received data byte and each write-direction address byte. The byte goes into the buffer and buffer-full is set. A host read strobe clears buffer-full.
- R4: A byte that arrives while buffer-full is set is NACKed. It sets the overflow flag and leaves the buffer unchanged.
- R5: If the buffer has been read but overflow is still set, the next byte is loaded and sets buffer-full, but it is still NACKed. Once software clears overflow, bytes are acknowledged again.
- R6: After a read-direction address byte, and after each transmitted byte that the master ACKs, the clock-release bit is cleared and SCL is held low. SCL is freed in the cycle after the host pulses `rel_set`.
- R7: A transmitted byte is the buffer content, sent MSB first. Buffer-full clears once all eight bits have shifted out.
- R8: A host write while a byte is shifting out sets the write-collision flag and does not change the byte being sent. Software clears the flag.
- R9: A master NACK on a transmitted byte leaves SCL released and clears the direction flag. The block then ignores the bus, and NACKs any further bytes, until the next start.
- R10: The direction flag copies bit 0 of the last matched address and is cleared by a start, a repeated start or a stop. The data/address flag is 1 after a data byte and 0 after an address byte.
- R11: The event flag sets at the end of each completed byte event and stays set until software pulses `evt_clr`.
- R12: The block changes its SDA pull only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low |
| own_addr | input | 8 | Slave address in bits 7:1; bit 0 unused |
| host_rd | input | 1 | Host read strobe: clears buffer-full |
| host_wr | input | 1 | Host write strobe: loads the buffer |
| host_wdata | input | 8 | Data for host writes |
| host_rdata | output | 8 | Current buffer content |
| rel_set | input | 1 | Sets the clock-release bit |
| ovf_clr | input | 1 | Clears the overflow flag |
| wcol_clr | input | 1 | Clears the write-collision flag |
| evt_clr | input | 1 | Clears the event flag |
| buf_full | output | 1 | Buffer-full flag |
| overflow | output | 1 | Overflow flag |
| wr_coll | output | 1 | Write-collision flag |
| dir_read | output | 1 | Direction of the last matched address (1 = read) |
| last_data | output | 1 | 1 if the last byte was data, 0 if an address |
| evt_flag | output | 1 | Byte-event flag |
| clk_rel | output | 1 | Clock-release bit |

## Verification
A bus edge reaches the engine three clocks after it appears on a line: two synchronizer flops and one edge register. The reaction is registered on the following edge. The behavioural master therefore changes SDA in the middle of the SCL low phase and samples it eight clocks into the high phase. This keeps every ACK and data bit far from its settling window.

Host strobes are driven at a falling edge for one clock. The flags are then read at the next falling edge, one cycle after the strobe, and the release of SCL after `rel_set` is checked in that same cycle. Stretch checks sample the wired SCL about a hundred clocks after the master has let its side go. At that point only the block can be holding the line low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RX   = 3'd1,
        PH_RACK = 3'd2,
        PH_TX   = 3'd3,
        PH_TACK = 3'd4
    } phase_t;

    typedef struct packed {
        phase_t              phase;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic [BYTE_W-1:0]   dbuf;
        logic                is_addr;
        logic                ackdrv;
        logic                mack;
        logic                bf;
        logic                ovf;
        logic                wcol;
        logic                rw;
        logic                da;
        logic                evt;
        logic                ckp;
    } eng_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dsync,
    output logic [WIDTH-1:0] dprev
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dsync = chain_q[STAGES-1];
    assign dprev = chain_q[STAGES];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic scl_s,
    input  logic scl_p,
    input  logic sda_s,
    input  logic sda_p,
    output logic start_p,
    output logic stop_p
);
    logic scl_high;
    assign scl_high = scl_s & scl_p;
    // SDA moving while SCL stays high marks a bus condition
    assign start_p  = scl_high & sda_p & ~sda_s;
    assign stop_p   = scl_high & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              rel_set,
    input  logic              ovf_clr,
    input  logic              wcol_clr,
    input  logic              evt_clr,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              buf_full,
    output logic              overflow,
    output logic              wr_coll,
    output logic              dir_read,
    output logic              last_data,
    output logic              evt_flag,
    output logic              clk_rel
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    eng_t q, d;
    logic scl_rise, scl_fall, addr_hit, shifting;
    logic [IDX_W-1:0] tx_idx;

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign addr_hit = (q.sh[BYTE_W-1:1] == own_addr[BYTE_W-1:1]);
    assign shifting = (q.phase == PH_TX) && q.ckp;
    assign tx_idx   = IDX_W'(CNT_LAST - q.cnt);

    always_comb begin
        d = q;
        // host side, overridden by bus events below
        if (rel_set)  d.ckp  = 1'b1;
        if (ovf_clr)  d.ovf  = 1'b0;
        if (wcol_clr) d.wcol = 1'b0;
        if (evt_clr)  d.evt  = 1'b0;
        if (host_rd)  d.bf   = 1'b0;
        if (host_wr) begin
            if (shifting) d.wcol = 1'b1;
            else begin
                d.dbuf = host_wdata;
                d.bf   = 1'b1;
            end
        end
        // bus side
        if (stop_p) begin
            d.phase  = PH_IDLE;
            d.rw     = 1'b0;
            d.ackdrv = 1'b0;
            d.ckp    = 1'b1;
        end else if (start_p) begin
            d.phase   = PH_RX;
            d.cnt     = '0;
            d.is_addr = 1'b1;
            d.rw      = 1'b0;
            d.ackdrv  = 1'b0;
            d.ckp     = 1'b1;
        end else begin
            unique case (q.phase)
                PH_RX: begin
                    if (scl_rise && q.cnt < CNT_FULL) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CNT_FULL) begin
                        if (q.is_addr && !addr_hit) begin
                            d.phase = PH_IDLE;
                        end else begin
                            d.phase = PH_RACK;
                            d.evt   = 1'b1;
                            d.da    = !q.is_addr;
                            if (q.is_addr) d.rw = q.sh[0];
                            if (q.is_addr && q.sh[0]) begin
                                d.ackdrv = 1'b1;
                            end else if (q.bf) begin
                                d.ovf    = 1'b1;
                                d.ackdrv = 1'b0;
                            end else begin
                                d.dbuf   = q.sh;
                                d.bf     = 1'b1;
                                d.ackdrv = !q.ovf;
                            end
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_fall) begin
                        d.ackdrv  = 1'b0;
                        d.cnt     = '0;
                        d.is_addr = 1'b0;
                        if (q.rw && q.is_addr) begin
                            d.phase = PH_TX;
                            d.ckp   = 1'b0;
                        end else begin
                            d.phase = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_LAST) begin
                            d.phase = PH_TACK;
                            d.bf    = 1'b0;
                        end
                    end
                end
                PH_TACK: begin
                    if (scl_rise) d.mack = ~sda_s;
                    if (scl_fall) begin
                        d.evt = 1'b1;
                        d.da  = 1'b1;
                        d.cnt = '0;
                        if (q.mack) begin
                            d.phase = PH_TX;
                            d.ckp   = 1'b0;
                        end else begin
                            d.phase = PH_IDLE;
                            d.rw    = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.ckp   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign scl_pull   = !q.ckp;
    assign sda_pull   = ((q.phase == PH_RACK) && q.ackdrv) ||
                        ((q.phase == PH_TX) && (q.cnt < CNT_FULL) && !q.dbuf[tx_idx]);
    assign host_rdata = q.dbuf;
    assign buf_full   = q.bf;
    assign overflow   = q.ovf;
    assign wr_coll    = q.wcol;
    assign dir_read   = q.rw;
    assign last_data  = q.da;
    assign evt_flag   = q.evt;
    assign clk_rel    = q.ckp;

    // R12: the SDA pull moves only while SCL is seen low
    p_sda_move_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s);
    // R4: a write byte that finds the buffer occupied is never acknowledged
    p_no_ack_on_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RACK && q.ovf && !q.rw) |-> !sda_pull);
    // R6: while the clock is held, no further bit is counted
    p_stretch_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_TX && !q.ckp) |=> $stable(q.cnt));
    // R3: a fresh write event always leaves the buffer marked full
    p_write_event_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.evt) && q.phase == PH_RACK && !q.rw) |-> q.bf);
    // R8: a collision never disturbs the buffer
    p_wcol_keeps_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wcol) |-> $stable(q.dbuf));
    // R9: an idle engine never holds the clock
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE) |-> !scl_pull);
endmodule

// File: rtl/i2c_byte_slave.sv
module i2c_byte_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              rel_set,
    input  logic              ovf_clr,
    input  logic              wcol_clr,
    input  logic              evt_clr,
    output logic              buf_full,
    output logic              overflow,
    output logic              wr_coll,
    output logic              dir_read,
    output logic              last_data,
    output logic              evt_flag,
    output logic              clk_rel
);
    localparam int LINES = 2;

    logic [LINES-1:0] lines_s, lines_p;
    logic start_p, stop_p;

    i2cs_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dsync (lines_s),
        .dprev (lines_p)
    );

    i2cs_cond u_cond (
        .scl_s   (lines_s[1]),
        .scl_p   (lines_p[1]),
        .sda_s   (lines_s[0]),
        .sda_p   (lines_p[0]),
        .start_p (start_p),
        .stop_p  (stop_p)
    );

    i2cs_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (lines_s[1]),
        .scl_p      (lines_p[1]),
        .sda_s      (lines_s[0]),
        .start_p    (start_p),
        .stop_p     (stop_p),
        .own_addr   (own_addr),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .rel_set    (rel_set),
        .ovf_clr    (ovf_clr),
        .wcol_clr   (wcol_clr),
        .evt_clr    (evt_clr),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull),
        .host_rdata (host_rdata),
        .buf_full   (buf_full),
        .overflow   (overflow),
        .wr_coll    (wr_coll),
        .dir_read   (dir_read),
        .last_data  (last_data),
        .evt_flag   (evt_flag),
        .clk_rel    (clk_rel)
    );
endmodule

// File: tb/i2c_byte_slave_bench.sv
module i2c_byte_slave_bench;
    localparam int T = 8;
    localparam logic [6:0] MY7 = 7'h22;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic mscl = 1'b1, msda = 1'b1;
    logic scl_bus, sda_bus;
    logic scl_pull, sda_pull;
    logic [7:0] own_addr = {MY7, 1'b1};
    logic host_rd = 0, host_wr = 0, rel_set = 0, ovf_clr = 0, wcol_clr = 0, evt_clr = 0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic buf_full, overflow, wr_coll, dir_read, last_data, evt_flag, clk_rel;

    assign scl_bus = mscl & ~scl_pull;
    assign sda_bus = msda & ~sda_pull;

    i2c_byte_slave u_i2c_byte_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(own_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rel_set(rel_set), .ovf_clr(ovf_clr),
        .wcol_clr(wcol_clr), .evt_clr(evt_clr), .buf_full(buf_full),
        .overflow(overflow), .wr_coll(wr_coll), .dir_read(dir_read),
        .last_data(last_data), .evt_flag(evt_flag), .clk_rel(clk_rel)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] rdv;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_rd;    host_rd = 1;  @(negedge clk); host_rd = 0;  endtask
    task automatic do_rel;   rel_set = 1;  @(negedge clk); rel_set = 0;  endtask
    task automatic do_oclr;  ovf_clr = 1;  @(negedge clk); ovf_clr = 0;  endtask
    task automatic do_wclr;  wcol_clr = 1; @(negedge clk); wcol_clr = 0; endtask
    task automatic do_eclr;  evt_clr = 1;  @(negedge clk); evt_clr = 0;  endtask
    task automatic do_wr(input logic [7:0] v);
        host_wdata = v; host_wr = 1; @(negedge clk); host_wr = 0;
    endtask

    // one SCL period: SDA set mid-low, sampled mid-high
    task automatic clk_bit(input logic b, output logic s);
        msda = b; wt(T);
        mscl = 1'b1;
        wait (scl_bus === 1'b1);
        @(negedge clk); wt(T);
        s = sda_bus; wt(T);
        mscl = 1'b0; wt(T);
    endtask

    task automatic mstart;
        msda = 1'b1; wt(T); mscl = 1'b1; wt(T); msda = 1'b0; wt(T); mscl = 1'b0; wt(T);
    endtask

    task automatic mstop;
        msda = 1'b0; wt(T); mscl = 1'b1; wt(T); msda = 1'b1; wt(2*T);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic nack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, nack);
    endtask

    task automatic rd_byte(output logic [7:0] dv, input logic give_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            dv[i] = s;
        end
        clk_bit(!give_ack, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic nk;
        wt(3); rst_n = 1'b1; wt(2);
        // R1 reset state
        chk("R1 scl_pull", scl_pull, 0); chk("R1 sda_pull", sda_pull, 0);
        chk("R1 flags", {buf_full, overflow, wr_coll, dir_read, last_data, evt_flag}, 0);
        chk("R1 clk_rel", clk_rel, 1);

        // R2 sweep over every 7-bit address (own_addr bit 0 is 1 and ignored)
        for (int a = 0; a < 128; a++) begin
            mstart;
            wr_byte({7'(a), 1'b0}, nk);
            chk("R2 ack by address", nk, (7'(a) != MY7));
            chk("R11 event on match only", evt_flag, (7'(a) == MY7));
            chk("R2 flags untouched on miss", buf_full, (7'(a) == MY7));
            if (7'(a) == MY7) begin
                chk("R10 write addr rw/da", {dir_read, last_data}, 2'b00);
                chk("R3 addr byte in buffer", host_rdata, {MY7, 1'b0});
                do_rd; chk("R3 read clears full", buf_full, 0);
                do_eclr; chk("R11 event cleared", evt_flag, 0);
            end
            mstop;
        end

        // R3 write data sweep
        mstart; wr_byte({MY7, 1'b0}, nk); do_rd; do_eclr;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 5) & 255);
            wr_byte(v, nk);
            chk("R3 data acked", nk, 0);
            chk("R3 data stored", host_rdata, v);
            chk("R10 data flag", {dir_read, last_data}, 2'b01);
            chk("R11 event per byte", evt_flag, 1);
            do_rd; do_eclr;
        end
        mstop;
        chk("R10 stop rw", dir_read, 0);

        // R4/R5 overflow
        mstart; wr_byte({MY7, 1'b0}, nk); do_eclr;
        wr_byte(8'h11, nk);
        chk("R4 nack when full", nk, 1);
        chk("R4 overflow set", overflow, 1);
        chk("R4 buffer kept", host_rdata, {MY7, 1'b0});
        do_rd;
        wr_byte(8'h22, nk);
        chk("R5 still nacked", nk, 1);
        chk("R5 loaded anyway", host_rdata, 8'h22);
        chk("R5 full again", buf_full, 1);
        do_rd; do_oclr;
        wr_byte(8'h33, nk);
        chk("R5 ack restored", nk, 0);
        chk("R5 stored", host_rdata, 8'h33);
        do_rd; mstop;

        // R6/R7/R8 read with stretch
        mstart; wr_byte({MY7, 1'b1}, nk);
        chk("R2 read addr acked", nk, 0);
        do_eclr;
        fork
            rd_byte(rdv, 1'b1);
            begin
                wt(100);
                chk("R6 held after addr", scl_bus, 0);
                chk("R10 read addr rw/da", {dir_read, last_data}, 2'b10);
                chk("R6 release bit cleared", clk_rel, 0);
                do_wr(8'hC3);
                wt(20);
                chk("R6 held until release", scl_bus, 0);
                do_rel;
                chk("R6 freed next cycle", scl_pull, 0);
                wt(40);
                do_wr(8'h0F);
                chk("R8 collision flag", wr_coll, 1);
                do_wclr;
                chk("R8 flag cleared", wr_coll, 0);
            end
        join
        chk("R7 msb first", rdv, 8'hC3);
        chk("R8 byte unchanged", host_rdata, 8'hC3);
        chk("R7 full cleared", buf_full, 0);
        chk("R11 event on master ack", evt_flag, 1);
        do_eclr;
        fork
            rd_byte(rdv, 1'b0);
            begin
                wt(100);
                chk("R6 held after acked byte", scl_bus, 0);
                do_wr(8'h5A); do_rel;
            end
        join
        chk("R7 second byte", rdv, 8'h5A);
        wt(5);
        chk("R9 scl free", scl_pull, 0);
        chk("R9 rw cleared", {dir_read, last_data}, 2'b01);
        wr_byte({MY7, 1'b0}, nk);
        chk("R9 ignored until start", nk, 1);
        chk("R9 buffer untouched", {buf_full, host_rdata}, {1'b0, 8'h5A});
        mstop;

        // R10 repeated start clears direction
        mstart; wr_byte({MY7, 1'b1}, nk);
        wt(50); do_wr(8'hFF); do_rel; wt(10);
        chk("R10 rw before restart", dir_read, 1);
        mstart;
        chk("R10 restart clears rw", dir_read, 0);
        mstop; do_rd;
        chk("R12 line free at end", sda_pull, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule